// File: doc/BRIEF.md
# Chroma Decimate/Interpolate FIR Chain

This block filters one chrominance channel through two half-band FIR stages in cascade. Each stage has 11 taps with fixed 10-bit weights, and each stage changes the sample rate by two. In decimating mode the block takes up to one signed sample per clock and produces one output for every fourth accepted sample. In interpolating mode it accepts one sample at most every fourth clock and produces four outputs on consecutive clocks. Samples move between the stages in a 15.3 signed word of 18 bits. Each stage forms the full-precision tap sum and rounds it back to that word. A formatting stage then produces a clipped 8-bit result in decimating mode, or a 10-bit integer in interpolating mode.

The input is either a 12-bit signed 9.3 word or an 8-bit signed integer. The integer form is scaled to the same 9.3 alignment. A second chroma channel is another instance of this block. The direction (`interp`) is static and may only change while reset is applied.

Interpolating mode is sequenced by two state machines. The first-stage machine runs S1_IDLE -> S1_EVEN (first stage forms its even-phase result) -> S1_GAP (a spacing cycle) -> S1_ODD (odd-phase result) -> S1_IDLE. A sample is accepted only in S1_IDLE. The second-stage machine runs S2_IDLE -> S2_EVEN_A -> S2_ODD_A -> S2_EVEN_B -> S2_ODD_B. The machine leaves S2_IDLE when a first-stage result arrives. In S2_ODD_A it takes the second first-stage result. From S2_ODD_B it goes back to S2_EVEN_A if a new result arrives, and otherwise to S2_IDLE. Decimating mode uses a one-bit phase flag per stage instead of these machines.

Top module: `chroma_fir_chain`

## Requirements
- R1: With `interp`=0, the block emits one output for every four accepted samples: on the 4th, 8th, 12th and later samples since reset. Two outputs never appear on adjacent clocks.
- R2: With `interp`=0, each stage forms the sum over its last 11 samples using the weights {6,0,-28,0,150,256,150,0,-28,0,6}. The sum is rounded as (sum+256)>>>9. Stage 1 produces a result on every second sample it takes, and stage 2 on every second stage-1 result.
- R3: With `interp`=1, each accepted sample produces exactly four outputs on consecutive clocks. Samples accepted every fourth clock produce an unbroken output stream.
- R4: With `interp`=1, each stage produces two results per sample it takes, even phase first. The even phase is the sum of the weights at positions 0,2,4,6,8,10 applied to the six newest samples, newest first. The odd phase is 256 times the third-newest sample. Both phases are rounded as (sum+128)>>>8.
- R5: With `interp`=1, a sample is accepted only when the first-stage machine is idle. `in_valid` in the three clocks after an accepted sample is ignored.
- R6: With `src_pins`=1, `din[7:0]` is read as a signed integer with zero fraction, and `din[11:8]` is ignored. With `src_pins`=0, `din` is a signed 9.3 value.
- R7: With `interp`=0 and `norm`=1, the output is the stage-2 word w rounded as (w+4)>>>3. This value is saturated to -128..127 and sign-extended to 10 bits.
- R8: With `interp`=0 and `norm`=0, the output is (w+8)>>>4 saturated to -128..127. This halves the unnormalized range.
- R9: With `interp`=1, the output is the low 10 bits of (w+4)>>>3, read as a signed integer.
- R10: A constant input settles to an output equal to its integer value in both directions (unity DC gain).
- R11: While reset is applied, `out_valid` and `dout` are 0. After reset all filter history is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interp | input | 1 | 1 = interpolate by four, 0 = decimate by four |
| norm | input | 1 | Decimating output alignment: 1 = 8.3 field, 0 = 9.3 field |
| src_pins | input | 1 | 1 = 8-bit integer input, 0 = 9.3 input |
| in_valid | input | 1 | Input sample strobe |
| din | input | 12 | Input sample |
| out_valid | output | 1 | Output sample strobe |
| dout | output | 10 | Output sample, signed |

## Verification
A stage line that shifts at the wrong moment, or a phase flag that is out of step, changes which samples make up each sum. It also moves the decimating output away from every fourth input. An impulse shows this within one output as a misplaced weight. A first-stage machine stuck outside S1_IDLE, or a second-stage machine that skips a state, breaks the four-output burst. The burst property catches this on the first interpolated sample. Wrong rounding or clipping shows up as an off-by-one or unsaturated value on the first affected output of a DC, step or random run.

// File: rtl/chroma_fir_pkg.sv
package chroma_fir_pkg;

    localparam int TAPS   = 11;
    localparam int CW     = 10;
    localparam int SW     = 18;
    localparam int FRAC   = 3;
    localparam int AW     = 32;
    localparam int DEC_SH = 9;
    localparam int INT_SH = 8;

    typedef enum logic [1:0] {
        S1_IDLE,
        S1_EVEN,
        S1_GAP,
        S1_ODD
    } s1_state_t;

    typedef enum logic [2:0] {
        S2_IDLE,
        S2_EVEN_A,
        S2_ODD_A,
        S2_EVEN_B,
        S2_ODD_B
    } s2_state_t;

    // Half-band weights, symmetric about the centre tap, summing to 512.
    function automatic logic signed [CW-1:0] tap(input int idx);
        int off;
        off = idx - TAPS / 2;
        if (off < 0) off = -off;
        case (off)
            0:       return CW'(256);
            1:       return CW'(150);
            3:       return CW'(-28);
            5:       return CW'(6);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/chroma_hb_stage.sv
module chroma_hb_stage
    import chroma_fir_pkg::*;
#(
    parameter int SWP   = SW,
    parameter int AWP   = AW,
    parameter int NTAP  = TAPS,
    parameter int DSH   = DEC_SH,
    parameter int ISH   = INT_SH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  interp,
    input  logic                  push,
    input  logic signed [SWP-1:0] din,
    input  logic                  fire,
    input  logic                  odd,
    output logic signed [SWP-1:0] dout,
    output logic                  dout_vld
);

    localparam int HALF    = NTAP / 2;
    localparam int NEVEN   = HALF + 1;
    localparam int ODD_IDX = (HALF - 1) / 2;

    logic signed [SWP-1:0] line [NTAP];
    logic signed [AWP-1:0] acc_full, acc_even, acc_odd, acc_sel, sum_r;
    logic signed [SWP-1:0] rounded;

    always_comb begin
        acc_full = '0;
        for (int j = 0; j < NTAP; j++) begin
            acc_full = acc_full + AWP'(tap(j)) * AWP'(line[j]);
        end
        acc_even = '0;
        for (int i = 0; i < NEVEN; i++) begin
            acc_even = acc_even + AWP'(tap(2 * i)) * AWP'(line[i]);
        end
        acc_odd = AWP'(tap(HALF)) * AWP'(line[ODD_IDX]);
    end

    always_comb begin
        if (interp) begin
            acc_sel = odd ? acc_odd : acc_even;
            sum_r   = acc_sel + AWP'(1 << (ISH - 1));
            rounded = SWP'(sum_r >>> ISH);
        end else begin
            acc_sel = acc_full;
            sum_r   = acc_sel + AWP'(1 << (DSH - 1));
            rounded = SWP'(sum_r >>> DSH);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAP; k++) line[k] <= '0;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            if (push) begin
                line[0] <= din;
                for (int k = 1; k < NTAP; k++) line[k] <= line[k-1];
            end
            dout_vld <= fire;
            if (fire) dout <= rounded;
        end
    end

endmodule

// File: rtl/chroma_fir_ctrl.sv
module chroma_fir_ctrl
    import chroma_fir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic interp,
    input  logic in_valid,
    input  logic s1_vld,
    output logic push1,
    output logic fire1,
    output logic odd1,
    output logic push2,
    output logic fire2,
    output logic odd2
);

    s1_state_t st1, st1_nx;
    s2_state_t st2, st2_nx;
    logic      ph1, ph2;
    logic      dfire1, dfire2;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1    <= S1_IDLE;
            st2    <= S2_IDLE;
            ph1    <= 1'b0;
            ph2    <= 1'b0;
            dfire1 <= 1'b0;
            dfire2 <= 1'b0;
        end else begin
            st1    <= st1_nx;
            st2    <= st2_nx;
            dfire1 <= !interp && push1 && ph1;
            dfire2 <= !interp && push2 && ph2;
            if (!interp && push1) ph1 <= !ph1;
            if (!interp && push2) ph2 <= !ph2;
        end
    end

    // Next-state logic
    always_comb begin
        st1_nx = st1;
        unique case (st1)
            S1_IDLE: if (interp && in_valid) st1_nx = S1_EVEN;
            S1_EVEN: st1_nx = S1_GAP;
            S1_GAP:  st1_nx = S1_ODD;
            S1_ODD:  st1_nx = S1_IDLE;
            default: st1_nx = S1_IDLE;
        endcase

        st2_nx = st2;
        unique case (st2)
            S2_IDLE:   if (interp && s1_vld) st2_nx = S2_EVEN_A;
            S2_EVEN_A: st2_nx = S2_ODD_A;
            S2_ODD_A:  st2_nx = S2_EVEN_B;
            S2_EVEN_B: st2_nx = S2_ODD_B;
            S2_ODD_B:  st2_nx = s1_vld ? S2_EVEN_A : S2_IDLE;
            default:   st2_nx = S2_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        push2 = s1_vld;
        if (interp) begin
            push1 = in_valid && (st1 == S1_IDLE);
            fire1 = (st1 == S1_EVEN) || (st1 == S1_ODD);
            odd1  = (st1 == S1_ODD);
            fire2 = (st2 != S2_IDLE);
            odd2  = (st2 == S2_ODD_A) || (st2 == S2_ODD_B);
        end else begin
            push1 = in_valid;
            fire1 = dfire1;
            odd1  = 1'b0;
            fire2 = dfire2;
            odd2  = 1'b0;
        end
    end

endmodule

// File: rtl/chroma_out_fmt.sv
module chroma_out_fmt
    import chroma_fir_pkg::*;
#(
    parameter int SWP   = SW,
    parameter int FR    = FRAC,
    parameter int OW    = 10,
    parameter int CLIPW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  interp,
    input  logic                  norm,
    input  logic                  in_vld,
    input  logic signed [SWP-1:0] w,
    output logic                  out_valid,
    output logic        [OW-1:0]  dout
);

    localparam int MAXV = (1 << (CLIPW - 1)) - 1;
    localparam int MINV = -(1 << (CLIPW - 1));

    logic signed [SWP:0]     wx, r_a, r_b, q_a, q_b, q_sel;
    logic signed [CLIPW-1:0] clip;
    logic        [OW-1:0]    nxt;

    always_comb begin
        wx  = {w[SWP-1], w};
        r_a = wx + (SWP+1)'(1 << (FR - 1));
        r_b = wx + (SWP+1)'(1 << FR);
        q_a = r_a >>> FR;
        q_b = r_b >>> (FR + 1);
        q_sel = (interp || norm) ? q_a : q_b;
        if (q_sel > MAXV)      clip = CLIPW'(MAXV);
        else if (q_sel < MINV) clip = CLIPW'(MINV);
        else                   clip = CLIPW'(q_sel);
        if (interp) nxt = OW'(q_a);
        else        nxt = OW'(clip);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dout      <= '0;
        end else begin
            out_valid <= in_vld;
            if (in_vld) dout <= nxt;
        end
    end

endmodule

// File: rtl/chroma_fir_chain.sv
module chroma_fir_chain
    import chroma_fir_pkg::*;
#(
    parameter int IW    = 12,
    parameter int PW    = 8,
    parameter int OW    = 10,
    parameter int CLIPW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          interp,
    input  logic          norm,
    input  logic          src_pins,
    input  logic          in_valid,
    input  logic [IW-1:0] din,
    output logic          out_valid,
    output logic [OW-1:0] dout
);

    logic signed [SW-1:0] x_in, s1_dout, s2_dout;
    logic s1_vld, s2_vld;
    logic push1, fire1, odd1, push2, fire2, odd2;

    always_comb begin
        if (src_pins) x_in = {{(SW-FRAC-PW){din[PW-1]}}, din[PW-1:0], {FRAC{1'b0}}};
        else          x_in = {{(SW-IW){din[IW-1]}}, din};
    end

    chroma_fir_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .interp(interp), .in_valid(in_valid),
        .s1_vld(s1_vld), .push1(push1), .fire1(fire1), .odd1(odd1),
        .push2(push2), .fire2(fire2), .odd2(odd2)
    );

    chroma_hb_stage u_st1 (
        .clk(clk), .rst_n(rst_n), .interp(interp), .push(push1), .din(x_in),
        .fire(fire1), .odd(odd1), .dout(s1_dout), .dout_vld(s1_vld)
    );

    chroma_hb_stage u_st2 (
        .clk(clk), .rst_n(rst_n), .interp(interp), .push(push2), .din(s1_dout),
        .fire(fire2), .odd(odd2), .dout(s2_dout), .dout_vld(s2_vld)
    );

    chroma_out_fmt #(.OW(OW), .CLIPW(CLIPW)) u_fmt (
        .clk(clk), .rst_n(rst_n), .interp(interp), .norm(norm),
        .in_vld(s2_vld), .w(s2_dout), .out_valid(out_valid), .dout(dout)
    );

endmodule

// File: rtl/chroma_fir_chain_chk.sv
module chroma_fir_chain_chk #(
    parameter int OW    = 10,
    parameter int CLIPW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          interp,
    input logic          push1,
    input logic          out_valid,
    input logic [OW-1:0] dout
);

    // R1: decimated outputs never sit on adjacent clocks
    p_dec_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!interp && out_valid) |=> !out_valid);

    // R3: an interpolated burst lasts at least four clocks
    p_int_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (interp && $rose(out_valid)) |=> out_valid ##1 out_valid ##1 out_valid);

    // R5: no second acceptance within three clocks
    p_int_accept_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (interp && push1) |=> !push1 ##1 !push1 ##1 !push1);

    // R7, R8: decimated output stays inside the clip range
    p_clip_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!interp && out_valid) |->
            ((&dout[OW-1:CLIPW-1]) || !(|dout[OW-1:CLIPW-1])));

    // R11: reset silences the output strobe
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

bind chroma_fir_chain chroma_fir_chain_chk u_chk (
    .clk(clk), .rst_n(rst_n), .interp(interp), .push1(push1),
    .out_valid(out_valid), .dout(dout)
);

// File: tb/chroma_fir_chain_tb.sv
module chroma_fir_chain_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        interp = 1'b0, norm = 1'b1, src_pins = 1'b0, in_valid = 1'b0;
    logic [11:0] din = '0;
    logic        out_valid;
    logic [9:0]  dout;

    int n_chk = 0, n_err = 0, cyc = 0;
    longint lm [2][11];
    bit     ph [2];
    longint exp_q[$], got_q[$];
    int     got_cyc[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    chroma_fir_chain u_dut (
        .clk(clk), .rst_n(rst_n), .interp(interp), .norm(norm), .src_pins(src_pins),
        .in_valid(in_valid), .din(din), .out_valid(out_valid), .dout(dout)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_q.push_back(longint'($signed(dout)));
            got_cyc.push_back(cyc);
        end
    end

    task automatic chk(bit ok, string req, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint tapv(int j);
        int off = (j > 5) ? j - 5 : 5 - j;
        case (off)
            0: return 256;
            1: return 150;
            3: return -28;
            5: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic longint rsh(longint a, int sh);
        return (a + (longint'(1) << (sh - 1))) >>> sh;
    endfunction

    function automatic longint conv(bit pins, logic [11:0] d);
        if (pins) return longint'($signed(d[7:0])) * 8;
        return longint'($signed(d));
    endfunction

    function automatic longint fmt(longint w);
        longint q;
        if (interp) begin
            q = ((w + 4) >>> 3) & 1023;
            if (q >= 512) q = q - 1024;
            return q;
        end
        q = norm ? ((w + 4) >>> 3) : ((w + 8) >>> 4);
        if (q > 127) q = 127;
        if (q < -128) q = -128;
        return q;
    endfunction

    task automatic st_push(int s, longint x);
        for (int k = 10; k > 0; k--) lm[s][k] = lm[s][k-1];
        lm[s][0] = x;
    endtask

    function automatic longint st_full(int s);
        longint a = 0;
        for (int j = 0; j < 11; j++) a += tapv(j) * lm[s][j];
        return a;
    endfunction

    function automatic longint st_even(int s);
        longint a = 0;
        for (int i = 0; i < 6; i++) a += tapv(2 * i) * lm[s][i];
        return a;
    endfunction

    task automatic mdl_dec(longint x);
        longint y1;
        st_push(0, x);
        if (ph[0]) begin
            y1 = rsh(st_full(0), 9);
            st_push(1, y1);
            if (ph[1]) exp_q.push_back(fmt(rsh(st_full(1), 9)));
            ph[1] = !ph[1];
        end
        ph[0] = !ph[0];
    endtask

    task automatic mdl_int(longint x);
        longint v [2];
        st_push(0, x);
        v[0] = rsh(st_even(0), 8);
        v[1] = rsh(256 * lm[0][2], 8);
        for (int p = 0; p < 2; p++) begin
            st_push(1, v[p]);
            exp_q.push_back(fmt(rsh(st_even(1), 8)));
            exp_q.push_back(fmt(rsh(256 * lm[1][2], 8)));
        end
    endtask

    task automatic start_test(bit im, bit nm, bit pins);
        @(negedge clk);
        in_valid = 1'b0;
        interp = im; norm = nm; src_pins = pins;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            ph[s] = 1'b0;
            for (int k = 0; k < 11; k++) lm[s][k] = 0;
        end
        exp_q.delete(); got_q.delete(); got_cyc.delete();
        rst_n = 1'b1;
    endtask

    task automatic dec_feed(logic [11:0] d);
        @(negedge clk);
        in_valid = 1'b1; din = d;
        mdl_dec(conv(src_pins, d));
    endtask

    task automatic int_feed(logic [11:0] d, bit noise);
        @(negedge clk);
        in_valid = 1'b1; din = d;
        mdl_int(conv(src_pins, d));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = noise; din = 12'($urandom() % 4096);
        end
    endtask

    task automatic drain_compare(string req);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (40) @(negedge clk);
        chk(got_q.size() == exp_q.size(), {req, " count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        // R11: quiet during reset
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && dout == '0, "R11 reset outputs", {out_valid, dout}, 0);

        // R1 R2 R7 R10: decimating DC from the 8-bit path
        start_test(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 64; i++) dec_feed(12'd37);
        drain_compare("R2 R7 dec DC");
        chk(got_q.size() == 16, "R1 dec output count", got_q.size(), 16);
        chk(got_q.size() > 0 && got_q[$] == 37, "R10 dec DC gain",
            got_q.size() > 0 ? got_q[$] : -999, 37);

        // R8 R10: unnormalized DC 200.0 halves to 100
        start_test(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 48; i++) dec_feed(12'd1600);
        drain_compare("R8 dec norm0 DC");
        chk(got_q.size() > 0 && got_q[$] == 100, "R8 R10 dec halved DC",
            got_q.size() > 0 ? got_q[$] : -999, 100);

        // R7: saturation at both ends
        start_test(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) dec_feed(12'h7FF);
        for (int i = 0; i < 40; i++) dec_feed(12'h800);
        drain_compare("R7 dec clip");
        chk(got_q.size() == 20 && got_q[9] == 127 && got_q[19] == -128, "R7 clip values",
            got_q.size() == 20 ? got_q[9] : -999, 127);

        // R2: impulse, then step with gaps in in_valid
        start_test(1'b0, 1'b1, 1'b1);
        dec_feed(12'd127);
        for (int i = 0; i < 31; i++) dec_feed(12'd0);
        for (int i = 0; i < 32; i++) begin
            dec_feed(12'hF9C);
            @(negedge clk); in_valid = 1'b0;
        end
        drain_compare("R2 dec impulse step");

        // R6: 8-bit path with random upper bits
        start_test(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 120; i++) dec_feed(12'($urandom() % 4096));
        drain_compare("R6 pins random");

        // R2 R8: random 9.3 input, unnormalized
        start_test(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 200; i++) dec_feed(12'($urandom() % 4096));
        drain_compare("R2 R8 dec random");

        // R3 R4 R10: interpolating DC
        start_test(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 16; i++) int_feed(12'd50, 1'b0);
        drain_compare("R4 int DC");
        chk(got_q.size() == 64, "R3 int output count", got_q.size(), 64);
        chk(got_q.size() > 0 && got_cyc[$] - got_cyc[0] + 1 == got_q.size(),
            "R3 int continuous stream",
            got_q.size() > 0 ? got_cyc[$] - got_cyc[0] + 1 : -1, got_q.size());
        chk(got_q.size() > 0 && got_q[$] == 50, "R10 int DC gain",
            got_q.size() > 0 ? got_q[$] : -999, 50);

        // R4 R9: impulse and step
        start_test(1'b1, 1'b0, 1'b0);
        int_feed(12'h7FF, 1'b0);
        for (int i = 0; i < 7; i++) int_feed(12'd0, 1'b0);
        for (int i = 0; i < 8; i++) int_feed(12'hCE0, 1'b0);
        for (int i = 0; i < 12; i++) int_feed(12'd1200, 1'b0);
        drain_compare("R4 R9 int impulse step");

        // R5: in_valid held high while busy is ignored
        start_test(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 30; i++) int_feed(12'($urandom() % 4096), 1'b1);
        drain_compare("R5 int busy ignore");
        chk(got_q.size() == 120, "R5 accepted count", got_q.size(), 120);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule